// File: doc/BRIEF.md
# Dual-Tuning Quad-Offset NCO Phase Engine

This block is the phase-generation core of a numerically controlled oscillator. A 32-bit phase accumulator advances by the selected tuning word on every clock edge. The top 12 bits of the new accumulator value, plus the selected 12-bit phase offset and taken modulo 4096, are registered as the output phase word. A sine lookup and converter downstream use this word. The output frequency is the tuning word times the clock rate divided by 2^32. One offset step is 2π/4096 radians.

There are two tuning registers and four offset registers, each written through its own commit strobe. A 1-bit frequency select and a 2-bit phase select choose among them at run time, so frequency-shift and phase-shift keying need no rewrites. With synchronous selection enabled, the selects are first captured in a register, so a change applies one edge later and only on a clock boundary. Three controls take over from normal running. Zero forcing holds the accumulator at zero. Hold freezes it. Clear zeroes both the accumulator and the captured selects. While any of them is active the output valid flag is low.

Top module: `nco_phase_core`

## Requirements
- R1: While rst_n is low and after its release, phase_out is 0 and phase_valid is 0, and every tuning and offset register reads as 0.
- R2: On each edge where acc_zero, acc_hold and clear are all low, the accumulator becomes its old value plus the selected tuning word, modulo 2^32. The output then becomes (accumulator[31:20] + selected offset) modulo 4096, and phase_valid is 1.
- R3: A tune_wr strobe writes tune_word into tuning register tune_idx (0 or 1), and the new word is first added on the edge after the strobe. A word greater than 32'h8000_0000 is discarded and the register keeps its old value. 32'h8000_0000 itself is accepted.
- R4: An ofs_wr strobe writes ofs_word into offset register ofs_idx (0 to 3), and the new offset is first used on the edge after the strobe.
- R5: freq_sel value n selects tuning register n, and phase_sel value n selects offset register n.
- R6: With sync_sel low, freq_sel and phase_sel act on the same edge they are sampled. With sync_sel high, the block uses the values captured at the previous edge.
- R7: acc_zero forces the accumulator to 0 and holds it there. The output is then the selected offset, and phase_valid is 0.
- R8: acc_hold (with acc_zero and clear low) keeps the accumulator unchanged and drives phase_valid to 0.
- R9: clear forces the accumulator and both captured selects to 0 and drives phase_valid to 0. clear and acc_zero take priority over acc_hold.
- R10: The accumulator and the output phase word both wrap modulo their width, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_wr | input | 1 | Commit strobe for a tuning word |
| tune_idx | input | 1 | Tuning register to write |
| tune_word | input | 32 | Tuning word to commit |
| ofs_wr | input | 1 | Commit strobe for a phase offset |
| ofs_idx | input | 2 | Offset register to write |
| ofs_word | input | 12 | Phase offset to commit |
| freq_sel | input | 1 | Tuning register select |
| phase_sel | input | 2 | Offset register select |
| sync_sel | input | 1 | Capture selects on the clock edge before use |
| acc_hold | input | 1 | Freeze the accumulator |
| acc_zero | input | 1 | Hold the accumulator at zero |
| clear | input | 1 | Zero the accumulator and captured selects |
| phase_out | output | 12 | Output phase word |
| phase_valid | output | 1 | Output is from a running accumulator |

## Verification
The assertions check on every cycle that a running edge adds exactly the active tuning word, that hold leaves the accumulator unchanged, and that zero forcing and clear leave it at zero. They also check that clear empties the captured selects, that discarded tuning words leave the bank untouched, and that valid is low after any takeover control. The bench scenarios alone can show which register a select value names, and the one-edge delay that synchronous selection adds. They also show when a committed word first appears in the output, the exact output value with offsets added and wrapped, and the boundary tuning word that is still accepted.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    ACC_RUN  = 2'd0,
    ACC_HOLD = 2'd1,
    ACC_ZERO = 2'd2
  } acc_mode_e;

  // Zeroing (acc_zero or clear) outranks hold.
  function automatic acc_mode_e acc_mode_f(input logic hold, input logic zero,
                                           input logic clr);
    if (zero || clr) return ACC_ZERO;
    if (hold)        return ACC_HOLD;
    return ACC_RUN;
  endfunction

endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank #(
  parameter int          W        = 32,
  parameter int          N        = 2,
  parameter bit          LIMIT_EN = 1'b0,
  parameter logic [W-1:0] LIMIT   = '1,
  localparam int         IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [N*W-1:0]   words_flat,
  output logic             wr_reject
);

  logic wr_accept;

  function automatic logic in_range(input logic [W-1:0] v);
    return !LIMIT_EN || (v <= LIMIT);
  endfunction

  assign wr_accept = wr_en && in_range(wr_data);
  assign wr_reject = wr_en && !wr_accept;

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    word_q <= '0;
      else if (wr_accept && (wr_idx == IDX_W'(i)))   word_q <= wr_data;
    end
    assign words_flat[i*W +: W] = word_q;
  end

endmodule

// File: rtl/nco_sel_sync.sv
module nco_sel_sync #(
  parameter int SW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          sync_en,
  input  logic [SW-1:0] sel_in,
  output logic [SW-1:0] sel_q,
  output logic [SW-1:0] sel_eff
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (clear) sel_q <= '0;
    else            sel_q <= sel_in;
  end

  assign sel_eff = sync_en ? sel_q : sel_in;

endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int TW_W = 32,
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  acc_mode_e       mode,
  input  logic [TW_W-1:0] step,
  input  logic [PH_W-1:0] offset,
  output logic [TW_W-1:0] acc_q,
  output logic [PH_W-1:0] phase_out,
  output logic            phase_valid
);

  logic [TW_W-1:0] acc_next;

  function automatic logic [PH_W-1:0] phase_word(input logic [TW_W-1:0] acc,
                                                 input logic [PH_W-1:0] ofs);
    return acc[TW_W-1 -: PH_W] + ofs;
  endfunction

  always_comb begin
    unique case (mode)
      ACC_ZERO: acc_next = '0;
      ACC_HOLD: acc_next = acc_q;
      default:  acc_next = acc_q + step;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      phase_out   <= '0;
      phase_valid <= 1'b0;
    end else begin
      acc_q       <= acc_next;
      phase_out   <= phase_word(acc_next, offset);
      phase_valid <= (mode == ACC_RUN);
    end
  end

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int TW_W   = 32,
  parameter int PH_W   = 12,
  parameter int N_TUNE = 2,
  parameter int N_OFS  = 4,
  localparam int TI_W  = (N_TUNE > 1) ? $clog2(N_TUNE) : 1,
  localparam int OI_W  = (N_OFS > 1) ? $clog2(N_OFS) : 1,
  localparam logic [TW_W-1:0] TW_LIMIT = TW_W'(1) << (TW_W - 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tune_wr,
  input  logic [TI_W-1:0] tune_idx,
  input  logic [TW_W-1:0] tune_word,
  input  logic            ofs_wr,
  input  logic [OI_W-1:0] ofs_idx,
  input  logic [PH_W-1:0] ofs_word,
  input  logic [TI_W-1:0] freq_sel,
  input  logic [OI_W-1:0] phase_sel,
  input  logic            sync_sel,
  input  logic            acc_hold,
  input  logic            acc_zero,
  input  logic            clear,
  output logic [PH_W-1:0] phase_out,
  output logic            phase_valid
);

  // Named internal events, observed by the bound checker.
  logic [N_TUNE*TW_W-1:0] tw_flat;
  logic [N_OFS*PH_W-1:0]  ofs_flat;
  logic                   tune_reject;
  logic                   ofs_reject;
  logic [TI_W-1:0]        fsel_q, fsel_eff;
  logic [OI_W-1:0]        psel_q, psel_eff;
  logic [TW_W-1:0]        tw_active;
  logic [PH_W-1:0]        ofs_active;
  logic [TW_W-1:0]        acc_q;
  acc_mode_e              mode;
  logic                   run_en;

  nco_word_bank #(.W(TW_W), .N(N_TUNE), .LIMIT_EN(1'b1), .LIMIT(TW_LIMIT)) i_tune_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(tune_wr), .wr_idx(tune_idx),
    .wr_data(tune_word), .words_flat(tw_flat), .wr_reject(tune_reject)
  );

  nco_word_bank #(.W(PH_W), .N(N_OFS), .LIMIT_EN(1'b0)) i_ofs_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(ofs_wr), .wr_idx(ofs_idx),
    .wr_data(ofs_word), .words_flat(ofs_flat), .wr_reject(ofs_reject)
  );

  nco_sel_sync #(.SW(TI_W)) i_fsel (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sync_en(sync_sel),
    .sel_in(freq_sel), .sel_q(fsel_q), .sel_eff(fsel_eff)
  );

  nco_sel_sync #(.SW(OI_W)) i_psel (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sync_en(sync_sel),
    .sel_in(phase_sel), .sel_q(psel_q), .sel_eff(psel_eff)
  );

  assign tw_active  = tw_flat[int'(fsel_eff)*TW_W +: TW_W];
  assign ofs_active = ofs_flat[int'(psel_eff)*PH_W +: PH_W];
  assign mode       = acc_mode_f(acc_hold, acc_zero, clear);
  assign run_en     = (mode == ACC_RUN);

  nco_accum #(.TW_W(TW_W), .PH_W(PH_W)) i_accum (
    .clk(clk), .rst_n(rst_n), .mode(mode), .step(tw_active),
    .offset(ofs_active), .acc_q(acc_q), .phase_out(phase_out),
    .phase_valid(phase_valid)
  );

endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk #(
  parameter int TW_W = 32,
  parameter int TI_W = 1,
  parameter int OI_W = 2,
  parameter int TWF_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_hold,
  input logic             acc_zero,
  input logic             clear,
  input logic             run_en,
  input logic             tune_reject,
  input logic [TWF_W-1:0] tw_flat,
  input logic [TW_W-1:0]  acc_q,
  input logic [TW_W-1:0]  tw_active,
  input logic [TI_W-1:0]  fsel_q,
  input logic [OI_W-1:0]  psel_q,
  input logic             phase_valid
);

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> acc_q == $past(acc_q + tw_active));

  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hold && !acc_zero && !clear) |=> $stable(acc_q));

  // R7
  acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_zero |=> acc_q == '0);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0) && (fsel_q == '0) && (psel_q == '0));

  // R3
  tune_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tune_reject |=> $stable(tw_flat));

  // R8
  valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hold || acc_zero || clear) |=> !phase_valid);

endmodule

bind nco_phase_core nco_phase_core_chk #(
  .TW_W(TW_W), .TI_W(TI_W), .OI_W(OI_W), .TWF_W(N_TUNE*TW_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .acc_hold(acc_hold), .acc_zero(acc_zero),
  .clear(clear), .run_en(run_en), .tune_reject(tune_reject),
  .tw_flat(tw_flat), .acc_q(acc_q), .tw_active(tw_active),
  .fsel_q(fsel_q), .psel_q(psel_q), .phase_valid(phase_valid)
);

// File: tb/test_nco_phase_core.sv
module test_nco_phase_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tune_wr = 1'b0;
  logic        tune_idx = 1'b0;
  logic [31:0] tune_word = '0;
  logic        ofs_wr = 1'b0;
  logic [1:0]  ofs_idx = '0;
  logic [11:0] ofs_word = '0;
  logic        freq_sel = 1'b0;
  logic [1:0]  phase_sel = '0;
  logic        sync_sel = 1'b0;
  logic        acc_hold = 1'b0;
  logic        acc_zero = 1'b1;
  logic        clear = 1'b0;
  logic [11:0] phase_out;
  logic        phase_valid;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference state, built from the requirements.
  logic [31:0] m_tw [2];
  logic [11:0] m_ofs [4];
  logic [31:0] m_acc;
  logic        m_fq;
  logic [1:0]  m_pq;

  always #4 clk = ~clk;

  nco_phase_core i_nco_phase_core (
    .clk(clk), .rst_n(rst_n), .tune_wr(tune_wr), .tune_idx(tune_idx),
    .tune_word(tune_word), .ofs_wr(ofs_wr), .ofs_idx(ofs_idx),
    .ofs_word(ofs_word), .freq_sel(freq_sel), .phase_sel(phase_sel),
    .sync_sel(sync_sel), .acc_hold(acc_hold), .acc_zero(acc_zero),
    .clear(clear), .phase_out(phase_out), .phase_valid(phase_valid)
  );

  task automatic check(input string tag, input logic [11:0] exp_out, input logic exp_v);
    tests++;
    if (phase_out !== exp_out || phase_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: phase_out=%0h valid=%0b expected phase_out=%0h valid=%0b",
               tag, phase_out, phase_valid, exp_out, exp_v);
    end
  endtask

  // Output phase: top 12 bits plus offset, wrapped to 12 bits (R2, R10).
  function automatic logic [11:0] ref_phase(input logic [31:0] acc, input logic [11:0] ofs);
    int unsigned s;
    s = (acc / 32'h0010_0000) + ofs;
    return 12'(s % 4096);
  endfunction

  // One clock edge: predict, advance, compare, update reference.
  task automatic cyc(input string tag);
    logic        fe;
    logic [1:0]  pe;
    logic [31:0] na;
    logic [11:0] eo;
    logic        ev;
    fe = sync_sel ? m_fq : freq_sel;
    pe = sync_sel ? m_pq : phase_sel;
    if (acc_zero || clear) na = 32'd0;
    else if (acc_hold)     na = m_acc;
    else                   na = 32'((64'(m_acc) + 64'(m_tw[fe])) % 64'h1_0000_0000);
    eo = ref_phase(na, m_ofs[pe]);
    ev = !(acc_zero || clear || acc_hold);
    @(posedge clk);
    #2;
    check(tag, eo, ev);
    m_acc = na;
    m_fq  = clear ? 1'b0 : freq_sel;
    m_pq  = clear ? 2'd0 : phase_sel;
    if (tune_wr && tune_word <= 32'h8000_0000) m_tw[tune_idx] = tune_word;
    if (ofs_wr) m_ofs[ofs_idx] = ofs_word;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic put_tune(input logic idx, input logic [31:0] w, input string tag);
    tune_wr = 1'b1; tune_idx = idx; tune_word = w;
    cyc(tag);
    tune_wr = 1'b0;
  endtask

  task automatic put_ofs(input logic [1:0] idx, input logic [11:0] w, input string tag);
    ofs_wr = 1'b1; ofs_idx = idx; ofs_word = w;
    cyc(tag);
    ofs_wr = 1'b0;
  endtask

  task automatic t_reset;
    #2;
    check("R1 during reset", 12'h000, 1'b0);
    rst_n = 1'b1;
    m_acc = '0; m_fq = '0; m_pq = '0;
    for (int i = 0; i < 2; i++) m_tw[i] = '0;
    for (int i = 0; i < 4; i++) m_ofs[i] = '0;
    run(2, "R1 after reset");
    // Registers read as zero: running with no writes leaves output 0.
    acc_zero = 1'b0;
    run(3, "R1 zero banks");
    check("R1 zero output", 12'h000, 1'b1);
  endtask

  task automatic t_basic;
    put_tune(1'b0, 32'h0100_0000, "R3 commit tw0");
    run(6, "R2 accumulate tw0");
    put_tune(1'b0, 32'h0003_5000, "R3 commit fine tw0");
    run(5, "R2 fine step");
  endtask

  task automatic t_reject;
    put_tune(1'b1, 32'h0200_0000, "R3 commit tw1");
    put_tune(1'b1, 32'h8000_0001, "R3 above limit");
    freq_sel = 1'b1;
    run(4, "R3 rejected word not used");
    put_tune(1'b1, 32'h8000_0000, "R3 limit accepted");
    run(4, "R10 wrap at half rate");
  endtask

  task automatic t_fsel;
    put_tune(1'b1, 32'h0123_4567, "R3 tw1");
    for (int i = 0; i < 6; i++) begin
      freq_sel = i[0];
      cyc("R5 freq select direct");
    end
  endtask

  task automatic t_offsets;
    put_ofs(2'd0, 12'h100, "R4 ofs0");
    put_ofs(2'd1, 12'h400, "R4 ofs1");
    put_ofs(2'd2, 12'h800, "R4 ofs2");
    put_ofs(2'd3, 12'hFFF, "R4 ofs3");
    for (int i = 0; i < 4; i++) begin
      phase_sel = 2'(i);
      run(2, "R5 phase select");
    end
    put_ofs(2'd3, 12'h7FF, "R4 rewrite in use");
    run(2, "R10 offset wrap");
  endtask

  task automatic t_sync;
    sync_sel = 1'b1;
    run(2, "R6 sync settle");
    freq_sel = 1'b0; phase_sel = 2'd1;
    cyc("R6 select delayed");
    freq_sel = 1'b1; phase_sel = 2'd2;
    cyc("R6 select delayed");
    run(3, "R6 select captured");
    sync_sel = 1'b0;
    phase_sel = 2'd0;
    cyc("R6 direct select");
  endtask

  task automatic t_hold;
    acc_hold = 1'b1;
    run(4, "R8 hold");
    phase_sel = 2'd3;
    cyc("R8 hold with offset change");
    acc_hold = 1'b0;
    run(2, "R8 resume");
  endtask

  task automatic t_zero;
    acc_zero = 1'b1;
    acc_hold = 1'b1;
    run(3, "R7 zero over hold");
    acc_hold = 1'b0;
    run(2, "R7 zero hold");
    check("R7 output equals offset", 12'h7FF, 1'b0);
    acc_zero = 1'b0;
    run(3, "R7 release");
  endtask

  task automatic t_clear;
    sync_sel = 1'b1;
    freq_sel = 1'b1; phase_sel = 2'd2;
    run(2, "R9 prepare");
    clear = 1'b1;
    cyc("R9 clear");
    clear = 1'b0;
    cyc("R9 selects cleared");
    run(3, "R9 run after clear");
    sync_sel = 1'b0;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_reject();
    t_fsel();
    t_offsets();
    t_sync();
    t_hold();
    t_zero();
    t_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule